// File: doc/BRIEF.md
# UART Idle and Break Monitor

This block sits next to a UART receiver. It watches two things: the stream of finished characters, each with its data and a flag for a missing stop bit, and the raw receive line, which it samples on the bit tick. It does two jobs.

The first job is idle detection. The block counts back-to-back all-ones characters. When the count reaches a programmable limit and a receive buffer is open, it asks for the buffer to be closed and raises a receive event. A limit of zero turns this off.

The second job is break detection. A break is an all-zero character whose stop bit is also zero. When a break sequence begins, the block adds one to a break error counter. If a buffer was open at that moment, it also closes the buffer and flags the break. While the line stays low it measures the break in character times. On the first one-level bit after the break it stores that length and pulses a break event. When synchronous mode and allow-zero-stop are both set, a break counts only after two break characters in a row.

Top module: `uart_idle_brk_mon`

## Requirements
- R1: A character counts as idle when its data is all ones and its stop bit was seen. When the idle run reaches `max_idle` and `buf_open` is 1, `close_req` and `rx_evt` each pulse for one cycle. The pulse comes in the cycle after the strobe of the character that reached the limit.
- R2: Any non-idle character sets the idle run back to zero. Another `max_idle` idle characters are then needed before the next pulse.
- R3: If `buf_open` is 0 when the limit is reached, neither output pulses. Idle characters that come later in the same run, even with a buffer open, also cause no pulse.
- R4: With `max_idle` equal to 0, no number of idle characters causes a pulse on `close_req` or `rx_evt`.
- R5: Within one idle run, the pulse fires at most once. The run counter saturates at the limit.
- R6: A break character has data all zero and the missing-stop flag set. The first break character of a sequence adds one to `brk_cnt`, and the new value shows in the next cycle. Later break characters in the same sequence leave `brk_cnt` unchanged.
- R7: A break ends on the first `bit_tick` that finds `line_lvl` at 1. In the next cycle `brk_evt` pulses for one cycle, and `brk_len` holds the number of break characters in the sequence. A tick that finds the line at 0 does not end the break.
- R8: At the start of a break with `buf_open` at 1, `close_req`, `rx_evt` and `brk_in_rx` each pulse for one cycle, at the same time as the `brk_cnt` step. With `buf_open` at 0, all three stay low.
- R9: When `sync_mode` and `allow_zs` are both 1, a break begins only on the second of two break characters in a row. Its length counts both characters. A single break character followed by any other character starts nothing.
- R10: An all-zero character that has its stop bit is an ordinary character. It resets the idle run and does not start a break. With `sync_mode` at 1 and `allow_zs` at 0, a single break character is enough to start a break.
- R11: `brk_len` counts in character times and saturates at its maximum value, which is all ones across `LEN_W` bits.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_vld | input | 1 | One-cycle strobe: a character is complete |
| char_data | input | DATA_W | Data of the completed character |
| char_frm | input | 1 | The completed character had no stop bit |
| line_lvl | input | 1 | Raw receive line level |
| bit_tick | input | 1 | One-cycle pulse per bit time, used to sample `line_lvl` |
| buf_open | input | 1 | A receive buffer is currently open |
| max_idle | input | IDLE_W | Idle-character limit; 0 disables idle detection |
| sync_mode | input | 1 | Receiver runs in synchronous mode |
| allow_zs | input | 1 | Characters without a stop bit are allowed |
| close_req | output | 1 | Pulse: close the open receive buffer |
| rx_evt | output | 1 | Pulse: receive interrupt event |
| brk_in_rx | output | 1 | Pulse: the buffer was closed because of a break |
| brk_evt | output | 1 | Pulse: first one after a break |
| brk_cnt | output | CNT_W | Break error counter (saturating) |
| brk_len | output | LEN_W | Length of the last break, in characters |

## Verification
The idle counter gets several kinds of runs, each aimed at a different fault:
- Runs that reach the limit tell a correct threshold from an off-by-one.
- Runs cut short by an ordinary character, including an all-zero character that has its stop bit, show whether the counter resets.
- Runs that keep going past the limit show whether the pulse repeats.
- A run that reaches the limit with no buffer open, then goes on with one open, shows whether a missed pulse fires late.

Break sequences are tried in three ways. One has a buffer open and one has none, which separates the close path from the counting path. The third takes a single break character, cuts it off, then sends two in a row under synchronous allow-zero-stop mode; this tells the double qualification apart from single-character detection. A long break checks the length saturation.

// File: rtl/umon_pkg.sv
package umon_pkg;
  typedef enum logic [1:0] {
    CK_NONE  = 2'd0,
    CK_IDLE  = 2'd1,
    CK_BREAK = 2'd2,
    CK_OTHER = 2'd3
  } char_kind_e;
endpackage

// File: rtl/umon_char_class.sv
module umon_char_class
  import umon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              char_vld,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_frm,
  output char_kind_e        kind
);
  always_comb begin
    if (!char_vld)                          kind = CK_NONE;
    else if (!char_frm && (&char_data))     kind = CK_IDLE;
    else if (char_frm && (char_data == '0)) kind = CK_BREAK;
    else                                    kind = CK_OTHER;
  end
endmodule

// File: rtl/umon_idle_ctr.sv
module umon_idle_ctr
  import umon_pkg::*;
#(
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  char_kind_e        kind,
  input  logic              buf_open,
  input  logic [IDLE_W-1:0] max_idle,
  output logic              idle_fire
);
  logic [IDLE_W-1:0] idle_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_run  <= '0;
      idle_fire <= 1'b0;
    end else begin
      idle_fire <= 1'b0;
      case (kind)
        CK_IDLE: begin
          if (max_idle != '0 && idle_run < max_idle) begin
            idle_run <= idle_run + 1'b1;
            if ((idle_run + 1'b1) == max_idle) idle_fire <= buf_open;
          end
        end
        CK_BREAK, CK_OTHER: idle_run <= '0;
        default: ;
      endcase
    end
  end

  // R4: a zero limit never fires
  p_no_fire_disabled_r4: assert property (@(posedge clk) disable iff (rst)
    idle_fire |-> ($past(max_idle) != '0));

  // R5: a fire is never followed directly by another
  p_single_fire_r5: assert property (@(posedge clk) disable iff (rst)
    idle_fire |=> !idle_fire);
endmodule

// File: rtl/umon_brk_trk.sv
module umon_brk_trk
  import umon_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  char_kind_e       kind,
  input  logic             line_lvl,
  input  logic             bit_tick,
  input  logic             buf_open,
  input  logic             sync_mode,
  input  logic             allow_zs,
  output logic             brk_open_p,
  output logic             brk_evt,
  output logic [CNT_W-1:0] brk_cnt,
  output logic [LEN_W-1:0] brk_len
);
  logic             in_brk;
  logic             zero_pend;
  logic [LEN_W-1:0] len_run;
  logic             need_two;

  assign need_two = sync_mode & allow_zs;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_brk     <= 1'b0;
      zero_pend  <= 1'b0;
      len_run    <= '0;
      brk_open_p <= 1'b0;
      brk_evt    <= 1'b0;
      brk_cnt    <= '0;
      brk_len    <= '0;
    end else begin
      brk_open_p <= 1'b0;
      brk_evt    <= 1'b0;
      if (in_brk) begin
        if (kind == CK_BREAK) begin
          if (len_run != '1) len_run <= len_run + 1'b1;
        end else if (bit_tick && line_lvl) begin
          in_brk  <= 1'b0;
          brk_evt <= 1'b1;
          brk_len <= len_run;
        end
      end else if (kind == CK_BREAK) begin
        if (need_two && !zero_pend) begin
          zero_pend <= 1'b1;
        end else begin
          zero_pend  <= 1'b0;
          in_brk     <= 1'b1;
          len_run    <= need_two ? LEN_W'(2) : LEN_W'(1);
          brk_open_p <= buf_open;
          if (brk_cnt != '1) brk_cnt <= brk_cnt + 1'b1;
        end
      end else if (kind != CK_NONE) begin
        zero_pend <= 1'b0;
      end
    end
  end

  // R6: the break counter only ever steps by one
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(brk_cnt) |-> (brk_cnt == $past(brk_cnt) + 1'b1));

  // R6: no count while a break continues
  p_cnt_once_r6: assert property (@(posedge clk) disable iff (rst)
    (in_brk && $past(in_brk)) |-> $stable(brk_cnt));

  // R7: the event marks the end of a break with a nonzero length
  p_evt_ends_r7: assert property (@(posedge clk) disable iff (rst)
    brk_evt |-> (!in_brk && $past(in_brk) && brk_len != '0));

  // R9: in double mode a break starts only after a pending zero character
  p_double_r9: assert property (@(posedge clk) disable iff (rst)
    (in_brk && !$past(in_brk) && $past(need_two)) |-> $past(zero_pend));
endmodule

// File: rtl/uart_idle_brk_mon.sv
module uart_idle_brk_mon
  import umon_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDLE_W = 16,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_vld,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_frm,
  input  logic              line_lvl,
  input  logic              bit_tick,
  input  logic              buf_open,
  input  logic [IDLE_W-1:0] max_idle,
  input  logic              sync_mode,
  input  logic              allow_zs,
  output logic              close_req,
  output logic              rx_evt,
  output logic              brk_in_rx,
  output logic              brk_evt,
  output logic [CNT_W-1:0]  brk_cnt,
  output logic [LEN_W-1:0]  brk_len
);
  char_kind_e kind;
  logic       idle_fire;
  logic       brk_open_p;

  umon_char_class #(.DATA_W(DATA_W)) u_class (
    .char_vld (char_vld),
    .char_data(char_data),
    .char_frm (char_frm),
    .kind     (kind)
  );

  umon_idle_ctr #(.IDLE_W(IDLE_W)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .kind     (kind),
    .buf_open (buf_open),
    .max_idle (max_idle),
    .idle_fire(idle_fire)
  );

  umon_brk_trk #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_brk (
    .clk       (clk),
    .rst       (rst),
    .kind      (kind),
    .line_lvl  (line_lvl),
    .bit_tick  (bit_tick),
    .buf_open  (buf_open),
    .sync_mode (sync_mode),
    .allow_zs  (allow_zs),
    .brk_open_p(brk_open_p),
    .brk_evt   (brk_evt),
    .brk_cnt   (brk_cnt),
    .brk_len   (brk_len)
  );

  assign close_req = idle_fire | brk_open_p;
  assign rx_evt    = idle_fire | brk_open_p;
  assign brk_in_rx = brk_open_p;

  // R1: a close request always follows a character strobe
  p_close_after_char_r1: assert property (@(posedge clk) disable iff (rst)
    close_req |-> $past(char_vld));

  // R8: no close request while no buffer was open
  p_close_needs_buf_r8: assert property (@(posedge clk) disable iff (rst)
    close_req |-> $past(buf_open));
endmodule

// File: tb/uart_idle_brk_mon_tb.sv
module uart_idle_brk_mon_tb;
  localparam int DATA_W = 8;
  localparam int IDLE_W = 8;
  localparam int CNT_W  = 16;
  localparam int LEN_W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic char_vld = 1'b0;
  logic [DATA_W-1:0] char_data = '0;
  logic char_frm = 1'b0;
  logic line_lvl = 1'b1;
  logic bit_tick = 1'b0;
  logic buf_open = 1'b0;
  logic [IDLE_W-1:0] max_idle = 8'd3;
  logic sync_mode = 1'b0;
  logic allow_zs = 1'b0;
  logic close_req, rx_evt, brk_in_rx, brk_evt;
  logic [CNT_W-1:0] brk_cnt;
  logic [LEN_W-1:0] brk_len;

  int checks = 0;
  int failures = 0;
  logic cap_close, cap_rx, cap_brk, cap_evt;

  always #5 clk = ~clk;

  uart_idle_brk_mon #(.DATA_W(DATA_W), .IDLE_W(IDLE_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .char_vld(char_vld), .char_data(char_data), .char_frm(char_frm),
    .line_lvl(line_lvl), .bit_tick(bit_tick), .buf_open(buf_open), .max_idle(max_idle),
    .sync_mode(sync_mode), .allow_zs(allow_zs), .close_req(close_req), .rx_evt(rx_evt),
    .brk_in_rx(brk_in_rx), .brk_evt(brk_evt), .brk_cnt(brk_cnt), .brk_len(brk_len)
  );

  // entry: data[12:5] frm[4] buf_open[3] exp_close[2] exp_rx[1] exp_brk_in_rx[0]
  localparam logic [12:0] VEC [16] = '{
    {8'hFF, 1'b0, 1'b1, 3'b000},  // R1 run 1
    {8'hFF, 1'b0, 1'b1, 3'b000},  // R1 run 2
    {8'hFF, 1'b0, 1'b1, 3'b110},  // R1 limit reached
    {8'hFF, 1'b0, 1'b1, 3'b000},  // R5 no repeat
    {8'h41, 1'b0, 1'b1, 3'b000},  // R2 reset by ordinary char
    {8'hFF, 1'b0, 1'b1, 3'b000},  // R2
    {8'hFF, 1'b0, 1'b1, 3'b000},  // R2
    {8'h41, 1'b0, 1'b1, 3'b000},  // R2 reset before limit
    {8'hFF, 1'b0, 1'b1, 3'b000},  // R3
    {8'hFF, 1'b0, 1'b1, 3'b000},  // R3
    {8'hFF, 1'b0, 1'b0, 3'b000},  // R3 limit, no buffer
    {8'hFF, 1'b0, 1'b1, 3'b000},  // R3 no late fire
    {8'h00, 1'b0, 1'b1, 3'b000},  // R10 zero char with stop bit
    {8'hFF, 1'b0, 1'b1, 3'b000},  // R10
    {8'hFF, 1'b0, 1'b1, 3'b000},  // R10
    {8'hFF, 1'b0, 1'b1, 3'b110}   // R10 count was reset
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic f, input logic bo);
    @(negedge clk);
    char_vld = 1'b1; char_data = d; char_frm = f; buf_open = bo;
    @(posedge clk); #1;
    cap_close = close_req; cap_rx = rx_evt; cap_brk = brk_in_rx;
    @(negedge clk);
    char_vld = 1'b0;
  endtask

  task automatic tick(input logic lvl);
    @(negedge clk);
    line_lvl = lvl; bit_tick = 1'b1;
    @(posedge clk); #1;
    cap_evt = brk_evt;
    @(negedge clk);
    bit_tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset outputs", {close_req, rx_evt, brk_in_rx, brk_evt, brk_cnt, brk_len}, '0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < 16; i++) begin
      send(VEC[i][12:5], VEC[i][4], VEC[i][3]);
      chk($sformatf("R1/R2/R3/R5/R10 vector %0d", i), {cap_close, cap_rx, cap_brk}, VEC[i][2:0]);
    end

    // async break with buffer open
    line_lvl = 1'b0;
    send(8'h00, 1'b1, 1'b1);
    chk("R8 break close flags", {cap_close, cap_rx, cap_brk}, 3'b111);
    chk("R6 break count first", brk_cnt, 1);
    send(8'h00, 1'b1, 1'b1);
    send(8'h00, 1'b1, 1'b1);
    chk("R6 no recount in sequence", brk_cnt, 1);
    chk("R8 no second close", {cap_close, cap_rx, cap_brk}, 3'b000);
    tick(1'b0);
    chk("R7 low tick keeps break", cap_evt, 0);
    tick(1'b1);
    chk("R7 break event", cap_evt, 1);
    chk("R7 break length", brk_len, 3);

    // break with no buffer
    line_lvl = 1'b0;
    send(8'h00, 1'b1, 1'b0);
    chk("R8 no close without buffer", {cap_close, cap_rx, cap_brk}, 3'b000);
    chk("R6 count without buffer", brk_cnt, 2);
    tick(1'b1);
    chk("R7 length single", brk_len, 1);

    // synchronous allow-zero-stop: double qualification
    sync_mode = 1'b1; allow_zs = 1'b1; line_lvl = 1'b0;
    send(8'h00, 1'b1, 1'b1);
    chk("R9 single zero no break", brk_cnt, 2);
    send(8'h41, 1'b0, 1'b1);
    send(8'h00, 1'b1, 1'b1);
    chk("R9 interrupted pair no break", brk_cnt, 2);
    send(8'h00, 1'b1, 1'b1);
    chk("R9 second zero starts break", brk_cnt, 3);
    chk("R9 close on start", {cap_close, cap_rx, cap_brk}, 3'b111);
    tick(1'b1);
    chk("R9 length counts both", brk_len, 2);

    // synchronous without allow-zero-stop: single is enough
    allow_zs = 1'b0; line_lvl = 1'b0;
    send(8'h00, 1'b1, 1'b1);
    chk("R10 sync single break", brk_cnt, 4);
    tick(1'b1);
    chk("R10 sync length", brk_len, 1);

    // length saturation
    sync_mode = 1'b0; line_lvl = 1'b0;
    for (int k = 0; k < 20; k++) send(8'h00, 1'b1, 1'b0);
    tick(1'b1);
    chk("R11 length saturates", brk_len, 15);
    chk("R6 count after long break", brk_cnt, 5);

    // disabled idle function
    max_idle = 8'd0;
    begin
      int fires = 0;
      for (int k = 0; k < 6; k++) begin
        send(8'hFF, 1'b0, 1'b1);
        if (cap_close || cap_rx) fires++;
      end
      chk("R4 zero limit disables", fires, 0);
    end

    finish_run();
  end
endmodule